// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is the bus master for a 16-bit processor core that reaches a 20-bit physical address space over shared pins. The core hands over one read or write request at a time. The sequencer then runs a fixed bus cycle of states T1, T2 and T3, any number of wait states (Tw), and T4. In T1 the shared lines carry the address, and an address-latch-enable pulse lets external latches hold it. After T1 the same lines carry write data, or float while read data comes back. The four upper lines carry address bits 19..16 in T1 and access status after T1.

The sequencer decodes the byte lanes from the transfer size and the low address bit. It stretches the cycle with a wait state for each low sample of READY. Between cycles it can hand the bus to another master, and all pin drivers are then released. Tristate control is brought out as enables (`ad_oe`, `bus_oe`), so the pad ring can build the actual three-state buffers. Every pin-facing output comes from a flop.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ale`=0, `ad_oe`=0, `rd_n`=1, `wr_n`=1, `bhe_n`=1, `bus_oe`=1, `hold_ack`=0, `busy`=0 and `rd_valid`=0.
- R2: In the cycle after a request is accepted (T1), `ale`=1 for exactly that one cycle and `ad_oe`=1. `ad_out` holds address bits 15..0, with bit 0 forced to 0 for word transfers. `as_out` holds address bits 19..16 for a memory access (`req_io`=0) and 0 for an I/O access.
- R3: In T2, T3, every Tw and T4, `as_out` carries status: bit 3 is 0, bit 2 is 0, and bits 1..0 hold the request's segment code. `bhe_n` is 1 in these states.
- R4: In T1, `bhe_n` is low when data moves on lane 15..8. For a word, `bhe_n`=0 and A0=0. For a byte at an odd address, `bhe_n`=0 and A0=1. For a byte at an even address, `bhe_n`=1 and A0=0.
- R5: A read drives `rd_n` low in T2, T3 and each Tw, and holds `ad_oe`=0 from T2 through T4. The value on `ad_in` at the clock edge that enters T4 appears on `rd_data` during T4, with `rd_valid`=1 for that single cycle.
- R6: A write drives `wr_n` low in T2, T3 and each Tw, and drives `req_wdata` on `ad_out` with `ad_oe`=1 from T2 through T4.
- R7: READY is sampled at the edge that ends T3 and at the edge that ends each Tw. Each low sample adds one Tw, and the first high sample leads to T4. With READY held high, a cycle occupies exactly four clocks.
- R8: A one-clock `req_valid` pulse starts a cycle when the sequencer is idle or in T4 (back to back, with no idle clock between). A pulse in T1, T2, T3 or Tw is ignored.
- R9: `hold_req` is honoured only from idle or at the end of T4, and it wins over a request in the same cycle. From the next clock, `hold_ack`=1, `bus_oe`=0 and `ad_oe`=0. Requests during hold are ignored. One clock after `hold_req` falls, the sequencer is idle with `bus_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 20 | Physical address |
| req_seg | input | 2 | Segment code for the status lines |
| req_wdata | input | 16 | Write data, lane-aligned |
| ready | input | 1 | Target ready, active high |
| hold_req | input | 1 | Another master requests the bus |
| ad_in | input | 16 | Shared lines as seen from the pads |
| ad_out | output | 16 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable of the shared lines |
| as_out | output | 4 | Upper address / status lines |
| bhe_n | output | 1 | High-byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ale | output | 1 | Address latch enable |
| bus_oe | output | 1 | Enable for all bus drivers (0 during hold) |
| hold_ack | output | 1 | Bus handed over |
| busy | output | 1 | A bus cycle is in progress |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | Read data valid pulse |

## Verification
Two pairs of events can land on the same clock edge. In the first, a new request and a hold request both arrive while the sequencer is idle or in T4. In the second, a request arrives in T4, which has to start the next T1 with no idle clock. The bench raises `hold_req` and `req_valid` together in idle, and again in T4 behind a running cycle. It then checks that hold is acknowledged on the next clock and that no address-latch pulse ever appears for the dropped request. In a separate sequence it issues a request in T4 and checks that `ale` rises on the very next clock with the new address. A sweep over direction, space, size, address parity and zero to two wait states checks every pin value in every state of each cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_state_e;

  function automatic logic in_data_phase(input bus_state_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
  endfunction

  function automatic logic in_strobe_phase(input bus_state_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready,
  input  logic              hold_req,
  output bus_state_e        st_d,
  output logic              nx_write,
  output logic              nx_io,
  output logic              nx_word,
  output logic [ADDR_W-1:0] nx_addr,
  output logic [SEG_W-1:0]  nx_seg,
  output logic [DATA_W-1:0] nx_wdata
);

  bus_state_e        st_q;
  logic              accept;
  logic              k_write, k_io, k_word;
  logic [ADDR_W-1:0] k_addr;
  logic [SEG_W-1:0]  k_seg;
  logic [DATA_W-1:0] k_wdata;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (hold_req) st_d = ST_HOLD;
               else if (req_valid) st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3,
      ST_TW:   st_d = ready ? ST_T4 : ST_TW;
      ST_T4:   if (hold_req) st_d = ST_HOLD;
               else if (req_valid) st_d = ST_T1;
               else st_d = ST_IDLE;
      ST_HOLD: st_d = hold_req ? ST_HOLD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign accept = (st_d == ST_T1);

  always_comb begin
    nx_write = accept ? req_write : k_write;
    nx_io    = accept ? req_io    : k_io;
    nx_word  = accept ? req_word  : k_word;
    nx_addr  = accept ? req_addr  : k_addr;
    nx_seg   = accept ? req_seg   : k_seg;
    nx_wdata = accept ? req_wdata : k_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      k_write <= 1'b0;
      k_io    <= 1'b0;
      k_word  <= 1'b0;
      k_addr  <= '0;
      k_seg   <= '0;
      k_wdata <= '0;
    end else begin
      st_q    <= st_d;
      k_write <= nx_write;
      k_io    <= nx_io;
      k_word  <= nx_word;
      k_addr  <= nx_addr;
      k_seg   <= nx_seg;
      k_wdata <= nx_wdata;
    end
  end

  // R7: a wait state exists only after a low READY sample
  p_tw_low_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TW) |-> !$past(ready));
  // R7: T4 follows a high sample taken in T3 or Tw
  p_t4_after_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T4) |-> ($past(ready) &&
      ($past(st_q) == ST_T3 || $past(st_q) == ST_TW)));
  // R8: a cycle starts only from idle or T4
  p_start_point_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T1) |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_T4));
  // R9: hold entered only between cycles
  p_hold_entry_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_HOLD) |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_T4));

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  bus_state_e               st_d,
  input  logic                     nx_write,
  input  logic                     nx_io,
  input  logic                     nx_word,
  input  logic [ADDR_W-1:0]        nx_addr,
  input  logic [SEG_W-1:0]         nx_seg,
  input  logic [DATA_W-1:0]        nx_wdata,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] as_out,
  output logic                     bhe_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     ale,
  output logic                     bus_oe,
  output logic                     hold_ack,
  output logic                     busy,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              is_t1, dphase, sphase;
  logic [DATA_W-1:0] addr_lo;
  logic [HI_W-1:0]   addr_hi, status;

  always_comb begin
    is_t1   = (st_d == ST_T1);
    dphase  = in_data_phase(st_d);
    sphase  = in_strobe_phase(st_d);
    addr_lo = nx_addr[DATA_W-1:0] & ~{{(DATA_W-1){1'b0}}, nx_word};
    addr_hi = nx_io ? '0 : nx_addr[ADDR_W-1:DATA_W];
    status  = HI_W'(nx_seg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out   <= '0;
      ad_oe    <= 1'b0;
      as_out   <= '0;
      bhe_n    <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      ale      <= 1'b0;
      bus_oe   <= 1'b1;
      hold_ack <= 1'b0;
      busy     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      ale      <= is_t1;
      ad_oe    <= is_t1 | (dphase & nx_write);
      ad_out   <= is_t1 ? addr_lo : ((dphase & nx_write) ? nx_wdata : '0);
      as_out   <= is_t1 ? addr_hi : (dphase ? status : '0);
      bhe_n    <= is_t1 ? ~(nx_word | nx_addr[0]) : 1'b1;
      rd_n     <= ~(sphase & ~nx_write);
      wr_n     <= ~(sphase & nx_write);
      bus_oe   <= (st_d != ST_HOLD);
      hold_ack <= (st_d == ST_HOLD);
      busy     <= is_t1 | dphase;
      rd_valid <= (st_d == ST_T4) & ~nx_write;
      if ((st_d == ST_T4) && !nx_write) rd_data <= ad_in;
    end
  end

  // R2: latch enable is a single-cycle pulse
  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  // R5: read strobe never overlaps a driven bus or a write strobe
  p_read_floats_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (!ad_oe && wr_n));
  // R6: write strobe only while data is driven
  p_write_driven_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);
  // R9: nothing is driven while the bus is handed over
  p_float_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (hold_ack && !ad_oe && !ale && rd_n && wr_n));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic                     req_word,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ready,
  input  logic                     hold_req,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] as_out,
  output logic                     bhe_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     ale,
  output logic                     bus_oe,
  output logic                     hold_ack,
  output logic                     busy,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);

  bus_state_e        st_d;
  logic              nx_write, nx_io, nx_word;
  logic [ADDR_W-1:0] nx_addr;
  logic [SEG_W-1:0]  nx_seg;
  logic [DATA_W-1:0] nx_wdata;

  mbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_word(req_word), .req_addr(req_addr),
    .req_seg(req_seg), .req_wdata(req_wdata), .ready(ready),
    .hold_req(hold_req), .st_d(st_d), .nx_write(nx_write), .nx_io(nx_io),
    .nx_word(nx_word), .nx_addr(nx_addr), .nx_seg(nx_seg), .nx_wdata(nx_wdata)
  );

  mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_drive (
    .clk(clk), .rst(rst), .st_d(st_d), .nx_write(nx_write), .nx_io(nx_io),
    .nx_word(nx_word), .nx_addr(nx_addr), .nx_seg(nx_seg),
    .nx_wdata(nx_wdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .as_out(as_out), .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .ale(ale),
    .bus_oe(bus_oe), .hold_ack(hold_ack), .busy(busy), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

endmodule

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0;
  logic        ready = 1'b1, hold_req = 1'b0;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out, rd_data;
  logic [3:0]  as_out;
  logic        ad_oe, bhe_n, rd_n, wr_n, ale, bus_oe, hold_ack, busy, rd_valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mux_bus_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_word(req_word), .req_addr(req_addr),
    .req_seg(req_seg), .req_wdata(req_wdata), .ready(ready),
    .hold_req(hold_req), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .as_out(as_out), .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .ale(ale),
    .bus_oe(bus_oe), .hold_ack(hold_ack), .busy(busy), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic set_req(input bit wr, input bit io, input bit word,
                         input logic [19:0] a, input logic [1:0] sg, input logic [15:0] wd);
    req_valid = 1'b1; req_write = wr; req_io = io; req_word = word;
    req_addr = a; req_seg = sg; req_wdata = wd;
  endtask

  // checks a state after T1; caller is at the negedge inside that state
  task automatic chk_data_state(input bit wr, input logic [1:0] sg,
                                input logic [15:0] wd, input bit strobe);
    chk("R2 ale low after T1", ale, 1'b0);
    chk("R3 status lines", as_out, {2'b00, sg});
    chk("R3 bhe_n status", bhe_n, 1'b1);
    chk("R5 rd_n", rd_n, !(strobe && !wr));
    chk("R6 wr_n", wr_n, !(strobe && wr));
    chk("R5/R6 ad_oe", ad_oe, wr);
    if (wr) chk("R6 write data", ad_out, wd);
  endtask

  // full cycle from the negedge before the request; ends at idle negedge
  task automatic run_cycle(input bit wr, input bit io, input bit word,
                           input logic [19:0] a, input logic [1:0] sg,
                           input logic [15:0] wd, input int nw, input logic [15:0] rv);
    @(negedge clk);
    set_req(wr, io, word, a, sg, wd);
    ad_in = ~rv; ready = 1'b1;
    @(negedge clk);                        // T1
    req_valid = 1'b0;
    chk("R2 ale in T1", ale, 1'b1);
    chk("R2 ad_oe in T1", ad_oe, 1'b1);
    chk("R2 busy", busy, 1'b1);
    chk("R2 address low", ad_out, {a[15:1], word ? 1'b0 : a[0]});
    chk("R2 address high", as_out, io ? 4'h0 : a[19:16]);
    chk("R4 bhe_n", bhe_n, !(word || a[0]));
    chk("R4 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    @(negedge clk);                        // T2
    chk_data_state(wr, sg, wd, 1'b1);
    @(negedge clk);                        // T3
    chk_data_state(wr, sg, wd, 1'b1);
    ready = (nw == 0);
    if (nw == 0) ad_in = rv;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);                      // Tw
      chk("R7 still stretched", busy, 1'b1);
      chk_data_state(wr, sg, wd, 1'b1);
      ready = (i == nw - 1);
      if (i == nw - 1) ad_in = rv;
    end
    @(negedge clk);                        // T4
    ad_in = 16'h0BAD;
    chk_data_state(wr, sg, wd, 1'b0);
    chk("R5 rd_valid in T4", rd_valid, !wr);
    if (!wr) chk("R5 read data", rd_data, rv);
    ready = 1'b1;
    @(negedge clk);                        // idle
    chk("R7 cycle ended", busy, 1'b0);
    chk("R5 rd_valid single", rd_valid, 1'b0);
    chk("R8 no spurious start", ale, 1'b0);
  endtask

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 ale", ale, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pins", {ad_oe, rd_n, wr_n, bhe_n, bus_oe, hold_ack, busy, rd_valid},
        8'b0_1_1_1_1_0_0_0);

    // sweep: direction, space, size/parity, wait states
    for (int w = 0; w < 2; w++)
      for (int io = 0; io < 2; io++)
        for (int bt = 0; bt < 4; bt++)
          for (int nw = 0; nw < 3; nw++) begin
            logic [19:0] a;
            a = 20'(((w * 7 + io * 3 + nw + 1) * 20'h1_1111) + bt * 16'h0203);
            a[0] = bt[0];
            run_cycle(w[0], io[0], bt[1], a, 2'(bt + nw),
                      16'(16'hA5C3 ^ (bt * 16'h0101 + nw)), nw,
                      16'(16'h3C5A + w * 16'h0111 + bt * 16'h1000 + nw));
          end

    // R7 exact length with READY high: request at n, idle visible at n+5 negedges
    run_cycle(1'b0, 1'b0, 1'b1, 20'h4_2468, 2'd1, 16'h0, 0, 16'hBEEF);

    // R8 request during T2 ignored
    @(negedge clk);
    set_req(1'b1, 1'b0, 1'b1, 20'h1_0000, 2'd0, 16'h1111);
    @(negedge clk); req_valid = 1'b0;      // T1
    @(negedge clk);                        // T2
    set_req(1'b1, 1'b0, 1'b1, 20'h2_2222, 2'd3, 16'h2222);
    @(negedge clk); req_valid = 1'b0;      // T3
    chk("R8 no ale mid-cycle", ale, 1'b0);
    @(negedge clk);                        // T4
    chk("R8 original data kept", ad_out, 16'h1111);
    @(negedge clk);
    chk("R8 ignored request not started", {busy, ale}, 2'b00);

    // R8 back-to-back: request in T4 starts T1 next clock
    @(negedge clk);
    set_req(1'b0, 1'b0, 1'b1, 20'h3_0010, 2'd2, 16'h0);
    @(negedge clk); req_valid = 1'b0;      // T1
    @(negedge clk); @(negedge clk);        // T3
    @(negedge clk);                        // T4
    set_req(1'b1, 1'b1, 1'b0, 20'h5_0021, 2'd1, 16'h7700);
    @(negedge clk); req_valid = 1'b0;
    chk("R8 back-to-back ale", ale, 1'b1);
    chk("R8 back-to-back address", ad_out, 16'h0021);
    chk("R2 io high lines zero", as_out, 4'h0);
    repeat (4) @(negedge clk);
    chk("R8 back-to-back done", busy, 1'b0);

    // R9 hold and request in the same idle cycle: hold wins
    set_req(1'b0, 1'b0, 1'b1, 20'h6_0000, 2'd0, 16'h0);
    hold_req = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk("R9 hold ack", {hold_ack, bus_oe, ad_oe}, 3'b100);
    chk("R9 request dropped", {ale, busy}, 2'b00);
    set_req(1'b0, 1'b0, 1'b1, 20'h6_0002, 2'd0, 16'h0);
    @(negedge clk); req_valid = 1'b0;
    chk("R9 request during hold ignored", {ale, busy, hold_ack}, 3'b001);
    hold_req = 1'b0;
    @(negedge clk);
    chk("R9 release", {hold_ack, bus_oe, busy, ale}, 4'b0100);

    // R9 hold during a cycle waits for T4, and beats a T4 request
    @(negedge clk);
    set_req(1'b0, 1'b0, 1'b1, 20'h7_0100, 2'd3, 16'h0);
    @(negedge clk); req_valid = 1'b0;      // T1
    @(negedge clk); hold_req = 1'b1;       // T2
    @(negedge clk);                        // T3
    chk("R9 no hold mid-cycle", {hold_ack, bus_oe}, 2'b01);
    @(negedge clk);                        // T4
    chk("R9 T4 reached under hold", busy, 1'b1);
    set_req(1'b1, 1'b0, 1'b1, 20'h7_0200, 2'd0, 16'h5555);
    @(negedge clk); req_valid = 1'b0;
    chk("R9 hold after T4", {hold_ack, bus_oe, ale}, 3'b100);
    hold_req = 1'b0;
    @(negedge clk);
    chk("R9 idle after hold", {hold_ack, busy, ale}, 3'b000);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule